// File: doc/BRIEF.md
# Counter-Driven Microcode Sequencer with Opcode Dispatch

This block produces the datapath control signals of a multicycle processor. A state register names the current control step. It addresses a small control store, and each word of that store holds the sixteen datapath control bits plus a two-bit next-address selector. The control bits are decoded from the registered state only, so they change only on a clock edge.

The selector chooses one of four sources for the next step:

- zero, which begins the next instruction;
- the current step plus one, supplied by an incrementer;
- a first opcode-indexed dispatch table;
- a second opcode-indexed dispatch table.

No separate next-state logic exists. Each control word states how to leave its own step.

The ten named states and their transitions are:

- FETCH (0) always goes to DECODE (1).
- DECODE uses dispatch table one. Loads and stores go to MEMADDR (2). Register ALU operations go to EXEC (6). Branches go to BRANCH (8). Jumps go to JUMP (9).
- MEMADDR uses dispatch table two. Loads go to MEMRD (3) and stores go to MEMWR (5).
- MEMRD steps to LDWB (4), and EXEC steps to RWB (7).
- LDWB, MEMWR, RWB, BRANCH and JUMP all return to FETCH.
- An opcode that a table does not list sends the sequencer back to FETCH.

The opcode is read only on the edges that leave DECODE and MEMADDR.

Top module: `ucode_seq`

## Requirements
- R1: While `rst` is high, the state register is forced to 0 (FETCH) on every clock edge. After reset, `state` reads 0 and `ctrl` reads 16'h9408.
- R2: Each state's two-bit next-address selector is used as follows: 0 loads state 0, 1 loads dispatch table one's entry, 2 loads dispatch table two's entry, and 3 loads the current state plus one. The selector values per state 0..9 are 3,1,2,3,0,0,3,0,0,0.
- R3: FETCH is always followed by DECODE on the next clock, whatever the opcode.
- R4: Dispatch table one, used in DECODE, maps opcode 6'h23 (load) and 6'h2B (store) to 2, 6'h00 (register ALU) to 6, 6'h04 (branch) to 8, and 6'h02 (jump) to 9.
- R5: Dispatch table two, used in MEMADDR, maps opcode 6'h23 to 3 and 6'h2B to 5.
- R6: Any opcode that a dispatch table does not list yields 0. A DECODE or MEMADDR step that sees such an opcode is followed by FETCH.
- R7: The number of cycles from one FETCH to the next is 5 for a load (0,1,2,3,4), 4 for a store (0,1,2,5), 4 for a register ALU operation (0,1,6,7), 3 for a branch (0,1,8) and 3 for a jump (0,1,9).
- R8: `ctrl` is a decode of the registered state. Its bit fields are:
  - [15] PC write
  - [14] conditional PC write
  - [13] memory address from ALU result
  - [12] memory read
  - [11] memory write
  - [10] instruction register write
  - [9] write-back from memory
  - [8:7] PC source
  - [6:5] ALU operation
  - [4:3] ALU B select
  - [2] ALU A from register
  - [1] register write
  - [0] destination from rd field

  The words for states 0..9 are 9408, 0018, 0014, 3000, 0202, 2800, 0044, 0003, 40A4 and 8100 (hex).
- R9: The opcode has no effect on the next state in any state other than DECODE and MEMADDR.
- R10: `state` never exceeds 9, and `ctrl` never asserts memory read and memory write together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the current instruction |
| ctrl | output | 16 | Datapath control bits for the current step |
| state | output | 4 | Current control step number |

## Verification
The assertions check the following on every cycle:

- the state is forced to FETCH during reset;
- FETCH is always followed by DECODE;
- the incrementing steps MEMRD and EXEC lead to LDWB and RWB;
- every terminal step returns to FETCH;
- MEMADDR only ever leads to MEMRD, MEMWR or FETCH;
- the state stays in range;
- memory read and memory write are never asserted together.

Only the bench's scenarios can show the rest. These are the exact contents of both dispatch tables, the full control word of each step, and the cycle count of each instruction class. They also include the fall-back to FETCH for unlisted opcodes and the insensitivity to opcode changes outside the two dispatch steps.

// File: rtl/ucode_pkg.sv
package ucode_pkg;

    parameter int STATE_W = 4;
    parameter int OP_W    = 6;
    parameter int CTRL_W  = 16;
    parameter int AC_W    = 2;
    parameter int NUM_ST  = 10;
    localparam int LAST_ST = NUM_ST - 1;

    typedef enum logic [STATE_W-1:0] {
        ST_FETCH   = 4'd0,
        ST_DECODE  = 4'd1,
        ST_MEMADDR = 4'd2,
        ST_MEMRD   = 4'd3,
        ST_LDWB    = 4'd4,
        ST_MEMWR   = 4'd5,
        ST_EXEC    = 4'd6,
        ST_RWB     = 4'd7,
        ST_BRANCH  = 4'd8,
        ST_JUMP    = 4'd9
    } state_e;

    typedef enum logic [AC_W-1:0] {
        AC_ZERO  = 2'd0,
        AC_DISP1 = 2'd1,
        AC_DISP2 = 2'd2,
        AC_SEQ   = 2'd3
    } addr_ctl_e;

    localparam logic [OP_W-1:0] OP_RALU  = 6'h00;
    localparam logic [OP_W-1:0] OP_JUMP  = 6'h02;
    localparam logic [OP_W-1:0] OP_BRNCH = 6'h04;
    localparam logic [OP_W-1:0] OP_LOAD  = 6'h23;
    localparam logic [OP_W-1:0] OP_STORE = 6'h2B;

    typedef struct packed {
        logic       pc_wr;
        logic       pc_wr_cond;
        logic       addr_alu;
        logic       mem_rd;
        logic       mem_wr;
        logic       ir_wr;
        logic       wb_mem;
        logic [1:0] pc_src;
        logic [1:0] alu_op;
        logic [1:0] alu_b;
        logic       alu_a_reg;
        logic       reg_wr;
        logic       dst_rd;
    } dp_ctrl_t;

    typedef struct packed {
        dp_ctrl_t  dp;
        addr_ctl_e ac;
    } ucode_word_t;

endpackage

// File: rtl/ucode_store.sv
module ucode_store
    import ucode_pkg::*;
(
    input  state_e      state_i,
    output ucode_word_t word_o
);

    always_comb begin
        word_o    = '0;
        word_o.ac = AC_ZERO;
        unique case (state_i)
            ST_FETCH: begin
                word_o.dp.mem_rd = 1'b1;
                word_o.dp.ir_wr  = 1'b1;
                word_o.dp.alu_b  = 2'b01;
                word_o.dp.pc_wr  = 1'b1;
                word_o.ac        = AC_SEQ;
            end
            ST_DECODE: begin
                word_o.dp.alu_b = 2'b11;
                word_o.ac       = AC_DISP1;
            end
            ST_MEMADDR: begin
                word_o.dp.alu_a_reg = 1'b1;
                word_o.dp.alu_b     = 2'b10;
                word_o.ac           = AC_DISP2;
            end
            ST_MEMRD: begin
                word_o.dp.mem_rd   = 1'b1;
                word_o.dp.addr_alu = 1'b1;
                word_o.ac          = AC_SEQ;
            end
            ST_LDWB: begin
                word_o.dp.reg_wr = 1'b1;
                word_o.dp.wb_mem = 1'b1;
                word_o.ac        = AC_ZERO;
            end
            ST_MEMWR: begin
                word_o.dp.mem_wr   = 1'b1;
                word_o.dp.addr_alu = 1'b1;
                word_o.ac          = AC_ZERO;
            end
            ST_EXEC: begin
                word_o.dp.alu_a_reg = 1'b1;
                word_o.dp.alu_op    = 2'b10;
                word_o.ac           = AC_SEQ;
            end
            ST_RWB: begin
                word_o.dp.reg_wr = 1'b1;
                word_o.dp.dst_rd = 1'b1;
                word_o.ac        = AC_ZERO;
            end
            ST_BRANCH: begin
                word_o.dp.alu_a_reg  = 1'b1;
                word_o.dp.alu_op     = 2'b01;
                word_o.dp.pc_wr_cond = 1'b1;
                word_o.dp.pc_src     = 2'b01;
                word_o.ac            = AC_ZERO;
            end
            ST_JUMP: begin
                word_o.dp.pc_wr  = 1'b1;
                word_o.dp.pc_src = 2'b10;
                word_o.ac        = AC_ZERO;
            end
            default: begin
                word_o    = '0;
                word_o.ac = AC_ZERO;
            end
        endcase
    end

endmodule

// File: rtl/ucode_dispatch.sv
module ucode_dispatch
    import ucode_pkg::*;
#(
    parameter int TABLE_SEL = 1
) (
    input  logic [OP_W-1:0] opcode_i,
    output state_e          target_o
);

    generate
        if (TABLE_SEL == 1) begin : g_table_one
            always_comb begin
                unique case (opcode_i)
                    OP_LOAD, OP_STORE: target_o = ST_MEMADDR;
                    OP_RALU:           target_o = ST_EXEC;
                    OP_BRNCH:          target_o = ST_BRANCH;
                    OP_JUMP:           target_o = ST_JUMP;
                    default:           target_o = ST_FETCH;
                endcase
            end
        end else begin : g_table_two
            always_comb begin
                unique case (opcode_i)
                    OP_LOAD:  target_o = ST_MEMRD;
                    OP_STORE: target_o = ST_MEMWR;
                    default:  target_o = ST_FETCH;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/ucode_next.sv
module ucode_next
    import ucode_pkg::*;
(
    input  state_e    state_i,
    input  addr_ctl_e ac_i,
    input  state_e    disp1_i,
    input  state_e    disp2_i,
    output state_e    next_o
);

    logic [STATE_W-1:0] incr;

    always_comb begin
        incr = state_i + STATE_W'(1);
        unique case (ac_i)
            AC_ZERO:  next_o = ST_FETCH;
            AC_DISP1: next_o = disp1_i;
            AC_DISP2: next_o = disp2_i;
            AC_SEQ:   next_o = state_e'(incr);
            default:  next_o = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
    import ucode_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   opcode,
    output logic [CTRL_W-1:0] ctrl,
    output logic [STATE_W-1:0] state
);

    state_e      state_q;
    state_e      state_d;
    state_e      disp1;
    state_e      disp2;
    ucode_word_t word;

    ucode_store u_store (
        .state_i (state_q),
        .word_o  (word)
    );

    ucode_dispatch #(.TABLE_SEL(1)) u_disp1 (
        .opcode_i (opcode),
        .target_o (disp1)
    );

    ucode_dispatch #(.TABLE_SEL(2)) u_disp2 (
        .opcode_i (opcode),
        .target_o (disp2)
    );

    ucode_next u_next (
        .state_i (state_q),
        .ac_i    (word.ac),
        .disp1_i (disp1),
        .disp2_i (disp2),
        .next_o  (state_d)
    );

    // State register process.
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FETCH;
        else     state_q <= state_d;
    end

    // Output process.
    always_comb begin
        ctrl  = word.dp;
        state = state_q;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (state == 4'd0));

    // R3
    fetch_decode_chk: assert property (@(posedge clk) disable iff (rst)
        (state == 4'd0) |=> (state == 4'd1));

    // R2
    step_incr_chk: assert property (@(posedge clk) disable iff (rst)
        (state == 4'd3 || state == 4'd6) |=> (state == $past(state) + 4'd1));

    // R7
    terminal_return_chk: assert property (@(posedge clk) disable iff (rst)
        (state == 4'd4 || state == 4'd5 || state == 4'd7 || state == 4'd8 || state == 4'd9)
        |=> (state == 4'd0));

    // R6
    memaddr_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (state == 4'd2) |=> (state == 4'd3 || state == 4'd5 || state == 4'd0));

    // R10
    state_range_chk: assert property (@(posedge clk) disable iff (rst)
        (32'(state) <= LAST_ST));

    // R10
    mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ctrl[12] && ctrl[11]));

endmodule

// File: tb/ucode_seq_tb_top.sv
`timescale 1ns/1ps
module ucode_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  opcode = 6'h00;
    logic [15:0] ctrl;
    logic [3:0]  state;
    int          n_checks = 0;
    int          n_fail = 0;
    int          cycles = 0;

    always #2.5 clk = ~clk;

    ucode_seq dut_i (
        .clk    (clk),
        .rst    (rst),
        .opcode (opcode),
        .ctrl   (ctrl),
        .state  (state)
    );

    function automatic logic [15:0] exp_ctrl(input logic [3:0] s);
        case (s)
            4'd0: return 16'h9408;
            4'd1: return 16'h0018;
            4'd2: return 16'h0014;
            4'd3: return 16'h3000;
            4'd4: return 16'h0202;
            4'd5: return 16'h2800;
            4'd6: return 16'h0044;
            4'd7: return 16'h0003;
            4'd8: return 16'h40A4;
            4'd9: return 16'h8100;
            default: return 16'h0000;
        endcase
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    // Walk a path of step numbers (MSB nibble first); the opcode may change to junk
    // outside the dispatch steps when scramble is set.
    task automatic run_path(input string req, input logic [5:0] op, input logic [23:0] path,
                            input int len, input bit scramble);
        for (int i = 0; i < len; i++) begin
            logic [3:0] s;
            s = path[(len-1-i)*4 +: 4];
            if (scramble && !(state == 4'd1 || state == 4'd2)) opcode = 6'(17 * i + 5);
            else opcode = op;
            chk({req, " state"}, 16'(state), 16'(s));
            chk("R8 ctrl", ctrl, exp_ctrl(state));
            @(posedge clk);
            @(negedge clk);
        end
        chk({req, " return to 0"}, 16'(state), 16'd0);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 state", 16'(state), 16'd0);
        chk("R1 ctrl", ctrl, 16'h9408);
        rst = 1'b0;
    endtask

    task automatic t_classes();
        run_path("R7 R4 R5 load",  6'h23, 24'h001234, 5, 1'b0);
        run_path("R7 R4 R5 store", 6'h2B, 24'h000125, 4, 1'b0);
        run_path("R7 R4 ralu",     6'h00, 24'h000167, 4, 1'b0);
        run_path("R7 R4 branch",   6'h04, 24'h000018, 3, 1'b0);
        run_path("R7 R4 jump",     6'h02, 24'h000019, 3, 1'b0);
    endtask

    task automatic t_undefined();
        run_path("R6 R3 table1 unlisted", 6'h3F, 24'h000001, 2, 1'b0);
        run_path("R6 table1 unlisted",    6'h2B ^ 6'h01, 24'h000001, 2, 1'b0);
        // load reaches MEMADDR, then a register ALU opcode is unlisted in table two
        opcode = 6'h23;
        chk("R6 state", 16'(state), 16'd0);
        @(posedge clk); @(negedge clk);
        chk("R6 state", 16'(state), 16'd1);
        @(posedge clk); @(negedge clk);
        chk("R2 R6 state", 16'(state), 16'd2);
        opcode = 6'h00;
        @(posedge clk); @(negedge clk);
        chk("R6 table2 unlisted", 16'(state), 16'd0);
    endtask

    task automatic t_ignored();
        run_path("R9 load scrambled",  6'h23, 24'h001234, 5, 1'b1);
        run_path("R9 ralu scrambled",  6'h00, 24'h000167, 4, 1'b1);
        run_path("R9 store scrambled", 6'h2B, 24'h000125, 4, 1'b1);
    endtask

    task automatic t_mid_reset();
        opcode = 6'h23;
        repeat (3) begin @(posedge clk); @(negedge clk); end
        chk("R1 pre-reset state", 16'(state), 16'd3);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R1 mid reset state", 16'(state), 16'd0);
        chk("R1 mid reset ctrl", ctrl, 16'h9408);
        rst = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_classes();
        t_undefined();
        t_ignored();
        t_mid_reset();
        run_path("R7 after reset jump", 6'h02, 24'h000019, 3, 1'b0);
        finish_run();
    end

endmodule